// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

This block is a down-counting watchdog driven by the system clock. Software stores a start value, picks what should happen on expiry, and turns the counter on. From then on, software has to restart the count before it runs out. If it misses that deadline, the block does one of two things, depending on the selected action. It can give a single-cycle interrupt pulse, either maskable or non-maskable. Or it can raise a reset request that stays high until it is acknowledged.

A reset-cause flag is held in a separate power-on domain. The system reset that the watchdog itself requests does not clear it. After a restart, software reads the flag to learn whether the watchdog caused that restart. Software clears the flag by writing a one to it.

Register access uses a write strobe with a 2-bit address. Read data is registered, so it appears one cycle after the address is presented.

Top module: `wdog_guard`

## Requirements
- R1: While `rst` and `por_rst` are high, and after they are released, all outputs read zero and the control, start-value and count registers read zero.
- R2: A write to address 1 (start value) sets both the stored start value and the live count; both read back the written value.
- R3: While enabled (control bit 0 = 1) and the count is non-zero, the count drops by exactly one per clock, for any start value up to the all-ones maximum.
- R4: Any write to address 2 (restart) reloads the count from the stored start value at the next clock edge, overriding that cycle's decrement, and re-arms expiry.
- R5: With action code 0 (control bits 2:1), expiry drives `irq_pulse` high for one cycle. That cycle follows the (C+1)-th clock edge after the count holds C with the timer enabled.
- R6: With action code 1, expiry gives the same one-cycle timing on `nmi_pulse`.
- R7: With action code 2, expiry raises `rst_req` with the same timing, and it stays high until `rst_ack` is sampled high.
- R8: A reset-type expiry sets the cause flag (control bit 3). The flag survives `rst`, is cleared by `por_rst`, and is cleared by writing control with bit 3 = 1.
- R9: While disabled, the count holds its value and no expiry output fires, even when the count is zero.
- R10: Each arming produces at most one expiry. After expiry the count stays at zero with no further pulse until a start-value or restart write.
- R11: `rst` clears a pending `rst_req`.
- R12: Action code 3 lets the count run to zero but raises no output.
- R13: `reg_rdata` shows the register selected by `reg_addr` one cycle later. Address 0 is control, 1 is start value, 2 (restart) reads zero, and 3 is the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| por_rst | input | 1 | Synchronous active-high power-on reset for the cause flag |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Registered read data |
| rst_ack | input | 1 | Acknowledge that drops a held reset request |
| irq_pulse | output | 1 | One-cycle maskable interrupt on expiry |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt on expiry |
| rst_req | output | 1 | Held reset request on expiry |

## Verification
The bench builds the block with a 12-bit counter instead of the default 32 bits. This puts the all-ones start value (4095) in reach: that full-range countdown, and its exact expiry cycle, fit inside the run. The narrow width changes none of the control encodings, so every action code, the restart race against a decrement, the freeze on disable and the survival of the cause flag across a reset are all exercised with short, hand-countable start values.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int ADDR_W    = 2;
  localparam int EN_BIT    = 0;
  localparam int ACT_LSB   = 1;
  localparam int ACT_W     = 2;
  localparam int CAUSE_BIT = 3;
  localparam int CTRL_BITS = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 2'd0,
    A_LOAD  = 2'd1,
    A_KICK  = 2'd2,
    A_COUNT = 2'd3
  } reg_sel_e;

  typedef enum logic [ACT_W-1:0] {
    ACT_IRQ = 2'd0,
    ACT_NMI = 2'd1,
    ACT_RST = 2'd2,
    ACT_OFF = 2'd3
  } act_e;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              cause_set,
  output logic              en,
  output act_e              act,
  output logic [CNT_W-1:0]  start_val,
  output logic              load_wr,
  output logic              kick_wr,
  output logic              cause,
  output logic [CNT_W-1:0]  reg_rdata
);

  logic             ctrl_wr;
  logic [CNT_W-1:0] ctrl_word;

  // write decode
  always_comb begin
    ctrl_wr = reg_we && (reg_sel_e'(reg_addr) == A_CTRL);
    load_wr = reg_we && (reg_sel_e'(reg_addr) == A_LOAD);
    kick_wr = reg_we && (reg_sel_e'(reg_addr) == A_KICK);
  end

  // control fields, cleared by system reset
  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= 1'b0;
      act <= ACT_IRQ;
    end else if (ctrl_wr) begin
      en  <= reg_wdata[EN_BIT];
      act <= act_e'(reg_wdata[ACT_LSB +: ACT_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_val <= '0;
    end else if (load_wr) begin
      start_val <= reg_wdata;
    end
  end

  // cause flag: only the power-on domain clears it; a new set beats a clear
  always_ff @(posedge clk) begin
    if (por_rst) begin
      cause <= 1'b0;
    end else if (cause_set) begin
      cause <= 1'b1;
    end else if (ctrl_wr && reg_wdata[CAUSE_BIT]) begin
      cause <= 1'b0;
    end
  end

  always_comb begin
    ctrl_word                      = '0;
    ctrl_word[EN_BIT]              = en;
    ctrl_word[ACT_LSB +: ACT_W]    = act;
    ctrl_word[CAUSE_BIT]           = cause;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (reg_sel_e'(reg_addr))
        A_CTRL:  reg_rdata <= ctrl_word;
        A_LOAD:  reg_rdata <= start_val;
        A_KICK:  reg_rdata <= '0;
        A_COUNT: reg_rdata <= cnt_val;
        default: reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_data,
  input  logic             kick_wr,
  input  logic [CNT_W-1:0] start_val,
  output logic [CNT_W-1:0] cnt_val,
  output logic             expire
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic spent;
  logic at_zero;

  assign at_zero = (cnt_val == '0);

  // expiry is offered once per arming, only while running
  assign expire = en && at_zero && !spent;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_val <= '0;
      spent   <= 1'b0;
    end else if (load_wr) begin
      cnt_val <= load_data;
      spent   <= 1'b0;
    end else if (kick_wr) begin
      cnt_val <= start_val;
      spent   <= 1'b0;
    end else if (en) begin
      if (!at_zero) begin
        cnt_val <= cnt_val - ONE;
      end else begin
        spent <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/wdog_action.sv
module wdog_action
  import wdog_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  act_e act,
  input  logic rst_ack,
  output logic irq_pulse,
  output logic nmi_pulse,
  output logic rst_req,
  output logic cause_set
);

  localparam int NPULSE = 2;

  logic [NPULSE-1:0] pulse_q;

  for (genvar g = 0; g < NPULSE; g++) begin : g_pulse
    localparam act_e SEL = (g == 0) ? ACT_IRQ : ACT_NMI;
    always_ff @(posedge clk) begin
      if (rst) begin
        pulse_q[g] <= 1'b0;
      end else begin
        pulse_q[g] <= expire && (act == SEL);
      end
    end
  end

  assign irq_pulse = pulse_q[0];
  assign nmi_pulse = pulse_q[1];
  assign cause_set = expire && (act == ACT_RST);

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req <= 1'b0;
    end else if (cause_set) begin
      rst_req <= 1'b1;
    end else if (rst_ack) begin
      rst_req <= 1'b0;
    end
  end

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              rst_ack,
  output logic              irq_pulse,
  output logic              nmi_pulse,
  output logic              rst_req
);

  logic             ctrl_en;
  act_e             ctrl_act;
  logic [CNT_W-1:0] start_val;
  logic             load_wr;
  logic             kick_wr;
  logic             cause_flag;
  logic             cause_set;
  logic [CNT_W-1:0] cnt_val;
  logic             expire;

  wdog_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .por_rst   (por_rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cnt_val   (cnt_val),
    .cause_set (cause_set),
    .en        (ctrl_en),
    .act       (ctrl_act),
    .start_val (start_val),
    .load_wr   (load_wr),
    .kick_wr   (kick_wr),
    .cause     (cause_flag),
    .reg_rdata (reg_rdata)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .en        (ctrl_en),
    .load_wr   (load_wr),
    .load_data (reg_wdata),
    .kick_wr   (kick_wr),
    .start_val (start_val),
    .cnt_val   (cnt_val),
    .expire    (expire)
  );

  wdog_action u_act (
    .clk       (clk),
    .rst       (rst),
    .expire    (expire),
    .act       (ctrl_act),
    .rst_ack   (rst_ack),
    .irq_pulse (irq_pulse),
    .nmi_pulse (nmi_pulse),
    .rst_req   (rst_req),
    .cause_set (cause_set)
  );

endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              rst_ack,
  input logic              irq_pulse,
  input logic              nmi_pulse,
  input logic              rst_req,
  input logic [CNT_W-1:0]  cnt_val,
  input logic              en,
  input logic              cause
);

  logic reload_wr;
  assign reload_wr = reg_we && ((reg_sel_e'(reg_addr) == A_LOAD) ||
                                (reg_sel_e'(reg_addr) == A_KICK));

  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (rst)
    (en && (cnt_val != '0) && !reload_wr) |=> (cnt_val == $past(cnt_val) - CNT_W'(1)));

  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse);

  // R6
  nmi_single_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_pulse |=> !nmi_pulse);

  // R10
  one_kind_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_pulse, nmi_pulse}));

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rst_req && !rst_ack) |=> rst_req);

  // R8
  cause_mark_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> cause);

  // R9
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !reload_wr) |=> $stable(cnt_val));

  // R9
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!irq_pulse && !nmi_pulse));

endmodule

bind wdog_guard wdog_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .rst_ack   (rst_ack),
  .irq_pulse (irq_pulse),
  .nmi_pulse (nmi_pulse),
  .rst_req   (rst_req),
  .cnt_val   (cnt_val),
  .en        (ctrl_en),
  .cause     (cause_flag)
);

// File: tb/sim_wdog_guard.sv
`timescale 1ns/1ps
module sim_wdog_guard;

  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          por_rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [CW-1:0] reg_wdata = '0;
  logic [CW-1:0] reg_rdata;
  logic          rst_ack = 1'b0;
  logic          irq_pulse, nmi_pulse, rst_req;

  always #4 clk = ~clk;

  wdog_guard #(.CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .por_rst(por_rst), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rst_ack(rst_ack), .irq_pulse(irq_pulse), .nmi_pulse(nmi_pulse),
    .rst_req(rst_req)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard for register reads
  logic [CW-1:0] exp_q[$];
  string         tag_q[$];
  logic          rd_fire = 1'b0;
  logic          mon_pend = 1'b0;

  always @(posedge clk) mon_pend <= rd_fire;

  always @(negedge clk) begin
    if (mon_pend && exp_q.size() > 0) begin
      logic [CW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, 32'(reg_rdata), 32'(e));
    end
  end

  task automatic wr(logic [1:0] a, logic [CW-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [CW-1:0] e, string t);
    reg_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_fire = 1'b1;
    @(negedge clk);
    rd_fire = 1'b0;
  endtask

  // kind: 0 irq, 1 nmi, 2 reset request
  task automatic expect_fire(int c, int kind, string t);
    int early = 0;
    for (int i = 0; i < c; i++) begin
      @(negedge clk);
      if (irq_pulse || nmi_pulse || rst_req) early++;
    end
    check({t, " no early expiry"}, early, 0);
    @(negedge clk);
    check({t, " irq"}, irq_pulse, kind == 0);
    check({t, " nmi"}, nmi_pulse, kind == 1);
    check({t, " req"}, rst_req, kind == 2);
    if (kind < 2) begin
      @(negedge clk);
      check({t, " single cycle"}, irq_pulse | nmi_pulse, 0);
    end
  endtask

  task automatic idle(int n, string t);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq_pulse || nmi_pulse || rst_req) seen++;
    end
    check(t, seen, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 outputs during reset
    check("R1 irq in reset", irq_pulse, 0);
    check("R1 req in reset", rst_req, 0);
    rst = 1'b0; por_rst = 1'b0;
    @(negedge clk);
    check("R1 nmi after reset", nmi_pulse, 0);
    rd(2'd0, '0, "R1 ctrl");
    rd(2'd1, '0, "R1 start");
    rd(2'd3, '0, "R1 count");

    // R2 start-value write sets stored value and count
    wr(2'd1, 12'd10);
    rd(2'd1, 12'd10, "R2 start readback");
    rd(2'd3, 12'd10, "R2 count readback");

    // R9 disabled: count frozen
    idle(5, "R9 disabled no output");
    rd(2'd3, 12'd10, "R9 frozen count");

    // R3 decrement per clock, irq action
    wr(2'd0, 12'h001);
    rd(2'd3, 12'd10, "R3 count t0");
    rd(2'd3, 12'd9,  "R3 count t1");
    rd(2'd3, 12'd8,  "R3 count t2");
    // R4 restart mid-count, then R5 irq expiry
    wr(2'd2, 12'd0);
    expect_fire(10, 0, "R4 R5 irq after restart");
    // R10 only one expiry per arming
    idle(20, "R10 no repeat");
    rd(2'd3, 12'd0, "R10 count stays zero");

    // R6 nmi action
    wr(2'd0, 12'h000);
    wr(2'd1, 12'd6);
    wr(2'd0, 12'h003);
    expect_fire(6, 1, "R6 nmi");

    // R12 action code 3 gives nothing
    wr(2'd0, 12'h000);
    wr(2'd1, 12'd4);
    wr(2'd0, 12'h007);
    idle(15, "R12 no output");
    rd(2'd3, 12'd0, "R12 count ran out");

    // R9 disable mid-count freezes
    wr(2'd0, 12'h000);
    wr(2'd1, 12'd20);
    wr(2'd0, 12'h001);
    repeat (5) @(negedge clk);
    wr(2'd0, 12'h000);
    idle(30, "R9 disabled mid-count quiet");
    rd(2'd3, 12'd14, "R9 count held");
    wr(2'd1, 12'd0);
    idle(10, "R9 zero while disabled quiet");

    // R7 reset action held until acknowledged; R8 cause flag
    wr(2'd1, 12'd5);
    wr(2'd0, 12'h005);
    expect_fire(5, 2, "R7 reset request");
    begin
      int drops = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (!rst_req) drops++;
      end
      check("R7 request held", drops, 0);
    end
    rd(2'd0, 12'h00D, "R8 flag set");
    rst_ack = 1'b1;
    @(negedge clk);
    rst_ack = 1'b0;
    check("R7 request dropped by ack", rst_req, 0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd(2'd0, 12'h008, "R8 flag survives rst");
    wr(2'd0, 12'h008);
    rd(2'd0, 12'h000, "R8 write-one clears flag");

    // R11 system reset drops request; R8 power-on clear
    wr(2'd1, 12'd2);
    wr(2'd0, 12'h005);
    expect_fire(2, 2, "R7 second request");
    rst = 1'b1;
    @(negedge clk);
    check("R11 rst clears request", rst_req, 0);
    rst = 1'b0;
    rd(2'd0, 12'h008, "R8 flag after second rst");
    por_rst = 1'b1;
    @(negedge clk);
    por_rst = 1'b0;
    rd(2'd0, 12'h000, "R8 por clears flag");

    // R13 address map
    wr(2'd1, 12'h05A);
    rd(2'd1, 12'h05A, "R13 start address");
    rd(2'd2, 12'h000, "R13 restart reads zero");
    rd(2'd3, 12'h05A, "R13 count address");

    // R3 R5 full-range start value
    wr(2'd1, 12'hFFF);
    wr(2'd0, 12'h001);
    expect_fire(4095, 0, "R3 R5 max start value");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule